// File: doc/BRIEF.md
# Four-Phase Quad-Lane Serial Flash Sequencer

This block is a register-programmed serial flash master. Software loads a transmit buffer, writes a control word and up to four phase words, then sets a start bit. The block holds one chip select low for the whole run and clocks through the phases back to back. Each phase carries its own lane count (one, two or four data lines), its own per-line output-enable pattern and its own number of serial clock cycles. Bits leave the transmit buffer from the top occupied byte downward, most significant bit first. Incoming bits are packed into a receive buffer in the same descending order.

Around the phases the block adds a programmable number of quiet serial-clock periods after chip select falls, before it rises, and with chip select high before the run ends. The serial clock is the bus clock divided by twice a divider value. Its resting level is programmable, so either clock-polarity convention can be used. Software polls the start bit, which reads 1 until the run has finished.

Top module: `qspi_step_seq`

## Requirements
- R1: After reset every chip select output is 1, `sclk` is 0, `dq_oe` is 0 and the start bit (offset 0x04, bit 0) reads 0.
- R2: Writing 1 to bit 0 at offset 0x04 starts a run only when the mode register (offset 0x00) holds 1. The bit reads 1 from the next cycle until the run ends and then returns to 0. With any other mode value the write has no effect.
- R3: A start write while a run is in progress is ignored: the edge count and all timing of the current run are unchanged.
- R4: The phase words sit at offsets 0x10, 0x14, 0x18 and 0x1C and run in that order. Bits 15:0 hold the cycle count. Bits 18:16 hold the lane count: 4 means quad, 2 means dual and any other value means single. Bits 23:20 drive `dq_oe` during the phase. A phase with count 0 is skipped. Each phase produces exactly its count of rising `sclk` edges.
- R5: The divider D is in control bits 7:0 (0 behaves as 1). Each half of an `sclk` period lasts D bus clocks, so rising edges are 2·D clocks apart. Outside the phases `sclk` rests at control bit 19. Inside a phase each cycle is a low half followed by a high half.
- R6: Let T be the sum of count × lanes over all phases. Transmit bits are taken from the buffer at offset 0x40 as a bit stream. The stream starts at bit T−1 (byte offset T/8−1, bit 7) and descends by the lane count each cycle. On a single-lane phase the bit is on `dq_out[0]`. On a dual phase it is on `dq_out[1:0]`, and on a quad phase on `dq_out[3:0]`, the higher line carrying the higher bit.
- R7: Each phase samples `dq_in` at its rising `sclk` edges. It stores the bits at the buffer at offset 0x80, starting at bit count × lanes − 1 and descending, so that its last byte lands at the lowest offset. A single-lane phase samples `dq_in[1]`. Dual and quad phases sample the higher line into the higher bit. The final non-skipped phase therefore leaves its bytes readable at offsets length−1 down to 0.
- R8: Chip select outputs equal the inverse of control bits 15:8 from the cycle after the start write until the post window ends. The first rising edge comes (2·pre+1)·D clocks after the fall, where pre is control bits 23:22. Chip select rises (1+2·post)·D clocks after the last rising edge, where post is control bits 21:20.
- R9: After chip select rises, the start bit keeps reading 1 for 2·idle·D more clocks, where idle is control bits 25:24.
- R10: `dq_out[3:1]` carries control bits 18:16 on every line that is not carrying data: lines 3..1 in a single-lane phase, lines 3..2 in a dual phase, and lines 3..1 outside the phases.
- R11: The mode, control and phase words read back at their offsets as written, with unused bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| sclk | output | 1 | Serial clock |
| cs_n | output | CS_W | Active-low chip selects |
| dq_out | output | 4 | Data line drive values |
| dq_oe | output | 4 | Data line output enables |
| dq_in | input | 4 | Data line inputs |

## Verification
The bench builds the block with its defaults: eight chip selects and 16-byte transmit and receive buffers. Sixteen bytes cover four phases of up to three bytes each, so a single-lane phase can reach 24 cycles within one run. The buffer words are small enough that every byte is written and read back on each run. Divider values of 0 to 3 keep each run to a few hundred clocks. This allows dozens of random phase mixes, both clock polarities and all pre, post and idle values inside the watchdog limit.

// File: rtl/qspi_step_seq.sv
module qspi_step_seq #(
  parameter int CS_W     = 8,
  parameter int TX_BYTES = 16,
  parameter int RX_BYTES = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      reg_addr,
  input  logic            reg_wr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            sclk,
  output logic [CS_W-1:0] cs_n,
  output logic [3:0]      dq_out,
  output logic [3:0]      dq_oe,
  input  logic [3:0]      dq_in
);
  localparam int TX_BITS = TX_BYTES * 8;
  localparam int RX_BITS = RX_BYTES * 8;
  localparam int TXW     = TX_BYTES / 4;
  localparam int RXW     = RX_BYTES / 4;
  localparam int TXWB    = $clog2(TXW);
  localparam int RXWB    = $clog2(RXW);
  localparam logic [2:0] P_POST = 3'd5, P_IDLE = 3'd7;

  logic [7:0]  mode_q;
  logic [25:0] ctrl_q;
  logic [23:0] ph_q [4];
  logic [31:0] txw [TXW];
  logic [31:0] rxw [RXW];
  logic [2:0]  pos, nxt, first;
  logic        half;
  logic [7:0]  dcnt;
  logic [15:0] cyc;
  logic [19:0] txp, rxp, tot;

  function automatic logic [15:0] cnt_of(input logic [2:0] p);
    case (p)
      3'd0:                return {14'd0, ctrl_q[23:22]};
      3'd1, 3'd2, 3'd3, 3'd4: return ph_q[2'(p - 3'd1)][15:0];
      3'd5:                return {14'd0, ctrl_q[21:20]};
      3'd6:                return {14'd0, ctrl_q[25:24]};
      default:             return 16'd0;
    endcase
  endfunction

  function automatic logic [2:0] lanes_of(input logic [23:0] w);
    return (w[18:16] == 3'd4) ? 3'd4 : (w[18:16] == 3'd2) ? 3'd2 : 3'd1;
  endfunction

  function automatic logic [19:0] span(input logic [2:0] p);
    return 20'(cnt_of(p)) * 20'(lanes_of(ph_q[2'(p - 3'd1)])) - 20'd1;
  endfunction

  function automatic logic txbit(input logic [19:0] i);
    return (i < 20'(TX_BITS)) ? txw[i[5 +: TXWB]][i[4:0]] : 1'b0;
  endfunction

  wire        busy   = pos != P_IDLE;
  wire        in_ph  = pos >= 3'd1 && pos <= 3'd4;
  wire [23:0] phw    = ph_q[2'(pos - 3'd1)];
  wire [2:0]  ln     = lanes_of(phw);
  wire [2:0]  idl    = ctrl_q[18:16];
  wire [7:0]  dlim   = (ctrl_q[7:0] == 8'd0) ? 8'd1 : ctrl_q[7:0];
  wire        tick   = busy && dcnt == dlim - 8'd1;
  wire        acc    = reg_wr && reg_addr[1:0] == 2'b00;
  wire        go_wr  = acc && reg_addr[7:2] == 6'h01 && reg_wdata[0];
  wire        start  = go_wr && !busy && mode_q == 8'd1;

  function automatic logic [1:0] lane_of(input int j);
    return (ln == 3'd1) ? 2'd1 : 2'(int'(ln) - 1 - j);
  endfunction

  always_comb begin
    nxt   = P_IDLE;
    first = P_IDLE;
    tot   = '0;
    for (int p = 6; p >= 0; p--) begin
      if (cnt_of(3'(p)) != 16'd0) begin
        first = 3'(p);
        if (3'(p) > pos) nxt = 3'(p);
      end
    end
    for (int i = 0; i < 4; i++) tot += 20'(ph_q[i][15:0]) * 20'(lanes_of(ph_q[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ctrl_q <= '0;
      for (int i = 0; i < 4; i++) ph_q[i] <= '0;
      for (int i = 0; i < TXW; i++) txw[i] <= '0;
    end else if (acc) begin
      case (reg_addr[7:6])
        2'b00: case (reg_addr[5:2])
          4'h0: mode_q <= reg_wdata[7:0];
          4'h2: ctrl_q <= reg_wdata[25:0];
          4'h4, 4'h5, 4'h6, 4'h7: ph_q[reg_addr[3:2]] <= reg_wdata[23:0];
          default: ;
        endcase
        2'b01: if (int'(reg_addr[5:2]) < TXW) txw[reg_addr[2 +: TXWB]] <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos  <= P_IDLE;
      half <= 1'b0;
      dcnt <= '0;
      cyc  <= '0;
      txp  <= '0;
      rxp  <= '0;
      for (int i = 0; i < RXW; i++) rxw[i] <= '0;
    end else if (start) begin
      pos  <= first;
      cyc  <= cnt_of(first);
      half <= 1'b0;
      dcnt <= '0;
      txp  <= tot - 20'd1;
      rxp  <= span(first);
    end else if (busy) begin
      dcnt <= tick ? 8'd0 : dcnt + 8'd1;
      if (tick) begin
        half <= ~half;
        if (!half && in_ph) begin
          for (int j = 0; j < 4; j++)
            if (j < int'(ln) && (rxp - 20'(j)) < 20'(RX_BITS))
              rxw[RXWB'((rxp - 20'(j)) >> 5)][5'(rxp - 20'(j))] <= dq_in[lane_of(j)];
        end
        if (half) begin
          if (in_ph) begin
            txp <= txp - 20'(ln);
            rxp <= rxp - 20'(ln);
          end
          if (cyc == 16'd1) begin
            pos <= nxt;
            cyc <= cnt_of(nxt);
            rxp <= span(nxt);
          end else begin
            cyc <= cyc - 16'd1;
          end
        end
      end
    end
  end

  assign sclk  = in_ph ? half : ctrl_q[19];
  assign cs_n  = (busy && pos <= P_POST) ? ~ctrl_q[8 +: CS_W] : '1;
  assign dq_oe = in_ph ? phw[23:20] : 4'h0;

  always_comb begin
    if (!in_ph)          dq_out = {idl, 1'b0};
    else if (ln == 3'd4) dq_out = {txbit(txp), txbit(txp - 20'd1), txbit(txp - 20'd2), txbit(txp - 20'd3)};
    else if (ln == 3'd2) dq_out = {idl[2:1], txbit(txp), txbit(txp - 20'd1)};
    else                 dq_out = {idl, txbit(txp)};
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr[7:6])
      2'b00: case (reg_addr[5:2])
        4'h0: reg_rdata = {24'd0, mode_q};
        4'h1: reg_rdata = {31'd0, busy};
        4'h2: reg_rdata = {6'd0, ctrl_q};
        4'h4, 4'h5, 4'h6, 4'h7: reg_rdata = {8'd0, ph_q[reg_addr[3:2]]};
        default: ;
      endcase
      2'b01: if (int'(reg_addr[5:2]) < TXW) reg_rdata = txw[reg_addr[2 +: TXWB]];
      2'b10: if (int'(reg_addr[5:2]) < RXW) reg_rdata = rxw[reg_addr[2 +: RXWB]];
      default: ;
    endcase
  end

  p_hold_between_ticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(pos) && $stable(half));
  p_go_busy_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && go_wr && !tick) |=> $stable(txp) && $stable(cyc));
  p_start_needs_go_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(go_wr) && $past(mode_q) == 8'd1);
  p_no_empty_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cyc != 16'd0);
  p_rx_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ph && tick && !half) |-> rxp < 20'(phw[15:0]) * 20'(ln));
endmodule

// File: tb/qspi_step_seq_tb.sv
`timescale 1ns/1ps
module qspi_step_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        sclk;
  logic [7:0]  cs_n;
  logic [3:0]  dq_out, dq_oe, dq_in = '0;

  qspi_step_seq dut_i (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .cs_n(cs_n),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in));

  int checks = 0, fails = 0;
  int c_pre, c_post, c_idle, c_div, c_cpol, c_cs;
  logic [2:0] c_idl;
  int pb[4], pl[4];
  bit pout[4];
  logic [7:0] txb[16];
  logic [3:0] rxstim[128];

  int ncyc = 0, t_csfall = -1, t_csrise = -1, t_done = 0, ne = 0;
  int e_t[128];
  logic [3:0] e_out[128], e_oe[128];
  logic psclk = 1'b0, pcs = 1'b0;

  always @(negedge clk) begin
    ncyc++;
    if (cs_n != 8'hFF && !pcs) t_csfall = ncyc;
    if (cs_n == 8'hFF && pcs) t_csrise = ncyc;
    if (cs_n != 8'hFF && sclk && !psclk && ne < 127) begin
      e_t[ne] = ncyc; e_out[ne] = dq_out; e_oe[ne] = dq_oe;
      ne++;
      dq_in = rxstim[ne];
    end
    psclk = sclk;
    pcs = (cs_n != 8'hFF);
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic logic txbit(input int g);
    return (g >= 0) ? txb[g / 8][g % 8] : 1'b0;
  endfunction

  function automatic logic [3:0] oe_of(input int l, input bit o);
    if (l == 1) return 4'hD;
    if (l == 2) return o ? 4'h3 : 4'hC;
    return o ? 4'hF : 4'h0;
  endfunction

  task automatic run_case(input bit go_again);
    logic [31:0] d;
    int dl, tot_b, tot_e, e, g, fin;
    logic [7:0] exp_rx[16];
    dl = (c_div == 0) ? 1 : c_div;
    wr(8'h08, (c_idle << 24) | (c_pre << 22) | (c_post << 20) | (c_cpol << 19) |
              (int'(c_idl) << 16) | ((1 << c_cs) << 8) | c_div);
    tot_b = 0; tot_e = 0; fin = -1;
    for (int i = 0; i < 4; i++) begin
      wr(8'(8'h10 + 4 * i), (int'(oe_of(pl[i], pout[i])) << 20) | (pl[i] << 16) | (pb[i] * 8 / pl[i]));
      tot_b += pb[i]; tot_e += pb[i] * 8 / pl[i];
      if (pb[i] > 0) fin = i;
    end
    for (int i = 0; i < 16; i++) txb[i] = 8'($urandom);
    for (int w = 0; w < 4; w++) wr(8'(8'h40 + 4 * w), {txb[4*w+3], txb[4*w+2], txb[4*w+1], txb[4*w]});
    for (int i = 0; i < 128; i++) rxstim[i] = 4'($urandom);
    dq_in = rxstim[0]; ne = 0; t_csfall = -1; t_csrise = -1;
    wr(8'h04, 32'h1);
    if (go_again) begin repeat (3) @(negedge clk); wr(8'h04, 32'h1); end
    for (int k = 0; k < 20000; k++) begin
      rd(8'h04, d);
      if (d[0] == 1'b0) break;
    end
    t_done = ncyc;
    chk(d[0] == 1'b0, "R2 start bit clears", d[0], 0);
    chk(ne == tot_e, go_again ? "R3 edge count with second start" : "R4 edge count", ne, tot_e);
    chk(cs_n == 8'hFF && sclk == 1'(c_cpol), "R5 idle after run", {cs_n, sclk}, {8'hFF, 1'(c_cpol)});
    if (tot_e > 0 && ne == tot_e) begin
      chk(e_t[0] - t_csfall == (2 * c_pre + 1) * dl, "R8 pre window", e_t[0] - t_csfall, (2 * c_pre + 1) * dl);
      for (int k = 1; k < ne; k++)
        chk(e_t[k] - e_t[k-1] == 2 * dl, "R5 sclk period", e_t[k] - e_t[k-1], 2 * dl);
      chk(t_csrise - e_t[ne-1] == dl * (1 + 2 * c_post), "R8 post window", t_csrise - e_t[ne-1], dl * (1 + 2 * c_post));
      chk(t_done - t_csrise == 2 * c_idle * dl, "R9 idle window", t_done - t_csrise, 2 * c_idle * dl);
      e = 0; g = tot_b * 8 - 1;
      for (int i = 0; i < 4; i++) begin
        for (int n = 0; n < pb[i] * 8 / pl[i]; n++) begin
          chk(e_oe[e] == oe_of(pl[i], pout[i]), "R4 output enable", e_oe[e], oe_of(pl[i], pout[i]));
          if (pl[i] == 1) begin
            chk(e_out[e][0] == txbit(g), "R6 single lane bit", e_out[e][0], txbit(g));
            chk(e_out[e][3:1] == c_idl, "R10 idle lines single", e_out[e][3:1], c_idl);
          end else if (pl[i] == 2) begin
            if (pout[i]) chk(e_out[e][1:0] == {txbit(g), txbit(g-1)}, "R6 dual lane bits", e_out[e][1:0], {txbit(g), txbit(g-1)});
            chk(e_out[e][3:2] == c_idl[2:1], "R10 idle lines dual", e_out[e][3:2], c_idl[2:1]);
          end else if (pout[i]) begin
            chk(e_out[e] == {txbit(g), txbit(g-1), txbit(g-2), txbit(g-3)}, "R6 quad lane bits",
                e_out[e], {txbit(g), txbit(g-1), txbit(g-2), txbit(g-3)});
          end
          g -= pl[i]; e++;
        end
      end
      if (fin >= 0) begin
        int base = 0;
        for (int i = 0; i < fin; i++) base += pb[i] * 8 / pl[i];
        for (int b = 0; b < 16; b++) exp_rx[b] = 8'h00;
        for (int n = 0; n < pb[fin] * 8 / pl[fin]; n++)
          for (int j = 0; j < pl[fin]; j++) begin
            int idx = pb[fin] * 8 - 1 - n * pl[fin] - j;
            exp_rx[idx / 8][idx % 8] = rxstim[base + n][(pl[fin] == 1) ? 1 : pl[fin] - 1 - j];
          end
        for (int b = 0; b < pb[fin]; b++) begin
          rd(8'(8'h80 + 4 * (b / 4)), d);
          chk(d[8*(b%4) +: 8] == exp_rx[b], "R7 receive byte", d[8*(b%4) +: 8], exp_rx[b]);
        end
      end
    end else if (tot_e == 0 && c_pre + c_post > 0) begin
      chk(t_csrise - t_csfall == 2 * (c_pre + c_post) * dl, "R8 empty phase window", t_csrise - t_csfall, 2 * (c_pre + c_post) * dl);
    end
  endtask

  task automatic rand_cfg();
    c_pre = $urandom % 4; c_post = $urandom % 4; c_idle = $urandom % 4;
    c_div = 1 + $urandom % 3; c_cpol = $urandom % 2; c_idl = 3'($urandom); c_cs = $urandom % 8;
    for (int i = 0; i < 4; i++) begin
      int s = $urandom % 3;
      pb[i] = $urandom % 4;
      pl[i] = (s == 0) ? 1 : (s == 1) ? 2 : 4;
      pout[i] = 1'($urandom);
    end
  endtask

  initial begin
    #(5.0 * 190000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(8'h04, d);
    chk(cs_n == 8'hFF && sclk == 1'b0 && dq_oe == 4'h0 && d[0] == 1'b0, "R1 reset state",
        {cs_n, sclk, dq_oe, d[0]}, {8'hFF, 1'b0, 4'h0, 1'b0});

    wr(8'h00, 32'h2);
    wr(8'h08, 32'h0030_0101);
    wr(8'h10, 32'h00D1_0008);
    t_csfall = -1;
    wr(8'h04, 32'h1);
    rd(8'h04, d);
    repeat (20) @(negedge clk);
    chk(d[0] == 1'b0 && t_csfall == -1, "R2 start ignored in other mode", {d[0], t_csfall == -1}, 2'b01);

    wr(8'h00, 32'hFFFF_FF01);
    rd(8'h00, d);
    chk(d == 32'h1, "R11 mode readback", d, 32'h1);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, d);
    chk(d == 32'h03FF_FFFF, "R11 control readback", d, 32'h03FF_FFFF);
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h1C, d);
    chk(d == 32'h00FF_FFFF, "R11 phase word readback", d, 32'h00FF_FFFF);

    c_pre = 0; c_post = 0; c_idle = 0; c_div = 0; c_cpol = 0; c_idl = 3'b111; c_cs = 0;
    pb = '{1, 0, 0, 2}; pl = '{1, 1, 1, 4}; pout = '{1, 1, 1, 0};
    run_case(1'b0);
    c_pre = 3; c_post = 3; c_idle = 3; c_div = 2; c_cpol = 1; c_idl = 3'b010; c_cs = 5;
    pb = '{1, 2, 0, 2}; pl = '{1, 2, 4, 2}; pout = '{1, 1, 1, 0};
    run_case(1'b1);
    c_pre = 1; c_post = 2; c_idle = 1; c_div = 1;
    pb = '{0, 0, 0, 0};
    run_case(1'b0);
    pb = '{3, 3, 3, 3}; pl = '{1, 1, 1, 1}; c_div = 3;
    run_case(1'b0);

    for (int r = 0; r < 40; r++) begin
      rand_cfg();
      run_case(r % 5 == 0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule